// File: doc/BRIEF.md
# Coalescing Interrupt Status Controller

This block sits on the host side of a command-queue storage controller. It collects interrupt status and gates it with an enable mask. It keeps one completed bit per command tag. Hardware sets that bit when the command finishes, and software clears it with a write-1 to the same bit. It then turns those completions into a single coalesced command-complete status bit. The bit rises when enough completions are pending or when the oldest pending completion has waited too long.

Besides command complete, a group of general event sources each set their own write-1-to-clear status bit. Every status bit, ANDed with its enable bit, feeds one registered interrupt line. A small link-state machine brings the controller online and takes it offline. Going offline passes through a drain phase that waits for every issued command to finish. While the controller is offline, the PHY reset output is held asserted. All configuration and status goes through a simple register port. A write takes effect on the next clock edge, and a read returns data one cycle after the read address is presented.

Top module: `irq_coalesce_ctrl`

## Requirements
- R1: After reset, irq_o is 0 and phy_rst_o is 1. The status word (address 0), the enable word (address 1), the completed word (address 2) and the control word (address 4) all read 0.
- R2: A pulse on ev_in[k] sets status bit k+1 on the next clock edge, whatever the value of enable bit k+1.
- R3: Writing a 1 to status bit k+1 (address 0) clears that bit, and writing a 0 leaves it alone. When an event and a clearing write hit the same bit in the same cycle, the bit stays set.
- R4: irq_o is a register. One edge after the status and enable registers change, it equals the OR over all bits of status ANDed with enable (enable at address 1, bit 0 for command complete, bits 1..NUM_EV for the events). It stays asserted while any enabled bit remains set.
- R5: cmd_done[t] sets completed bit t on the next edge. Writing 1 to bit t of address 2 clears it. A set and a clear on the same bit in the same cycle leave the bit set.
- R6: The command-complete status bit (status bit 0) is set one edge after the number of set completed bits first reaches the count threshold (address 3 bits [5:0]).
- R7: An age timer reads 0 on the edge where the completed word becomes non-empty and counts up by 1 on each later edge while the word stays non-empty. Command complete sets on the edge after the timer equals the timeout (address 3 bits [31:16]). The timer is cleared whenever the word is empty.
- R8: Command complete clears one edge after the pending count drops below the threshold while the age is below the timeout, and also once the completed word is empty. Writing to status bit 0 has no effect on it.
- R9: Writing 1 to control bit 0 (address 4) while offline sets online and releases phy_rst_o on the next edge. Writing 0 while online sets going-offline (status bit 30, with online at status bit 31). One edge after the count of outstanding commands is zero, both bits clear and phy_rst_o asserts.
- R10: cmd_issue[t] marks tag t as outstanding only while the controller is online and not going offline. At other times it is ignored.
- R11: Reading any register returns its contents one edge after rd_addr is presented. The configuration word at address 3 reads back the threshold and timeout as they were written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register write address |
| wr_data | input | 32 | Register write data |
| rd_addr | input | 3 | Register read address |
| rd_data | output | 32 | Registered read data |
| ev_in | input | 8 | Event pulses, one per general source |
| cmd_issue | input | 32 | Per-tag issue pulses |
| cmd_done | input | 32 | Per-tag completion pulses |
| irq_o | output | 1 | Registered interrupt line |
| phy_rst_o | output | 1 | PHY reset, high while offline |

## Verification
Each result has a fixed delay. A status bit, a completed bit or a link-state change shows on the edge that captures its stimulus. The command-complete bit comes one edge after the count or age condition is met, and irq_o one edge after the status bit. Read data comes one edge after the address. Stimulus is driven one time unit after a rising edge, and every check is made after the exact number of edges that chain implies. The cycle before each expected change is checked as well as the cycle of the change, so a result one edge early or late is caught. The age-timeout case is run twice, to show that the timer restarts once the completed word has been emptied and filled again.

// File: rtl/irqc_pkg.sv
package irqc_pkg;
  localparam int ADDR_W = 3;
  localparam int TMO_LSB = 16;

  typedef enum logic [ADDR_W-1:0] {
    A_STAT = 3'd0,
    A_ENAB = 3'd1,
    A_DONE = 3'd2,
    A_COAL = 3'd3,
    A_CTRL = 3'd4
  } reg_addr_e;
endpackage

// File: rtl/cmd_track.sv
module cmd_track #(
  parameter int N = 32
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         accept,
  input  logic [N-1:0] cmd_issue,
  input  logic [N-1:0] cmd_done,
  input  logic [N-1:0] clr_mask,
  output logic [N-1:0] done_q,
  output logic         active_any
);
  logic [N-1:0] active_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      active_q <= '0;
      done_q   <= '0;
    end else begin
      active_q <= (active_q | (accept ? cmd_issue : '0)) & ~cmd_done;
      done_q   <= (done_q & ~clr_mask) | cmd_done;
    end
  end

  assign active_any = |active_q;

  // completion must be recorded even when cleared in the same cycle
  p_done_wins_r5: assert property (@(posedge clk) disable iff (rst)
    (cmd_done != '0) |=> ((done_q & $past(cmd_done)) == $past(cmd_done)));

  // issue outside the accepting window adds no outstanding tag
  p_issue_gate_r10: assert property (@(posedge clk) disable iff (rst)
    (!accept && active_q == '0) |=> (active_q == '0));
endmodule

// File: rtl/coalesce_eng.sv
module coalesce_eng #(
  parameter int N     = 32,
  parameter int CNT_W = 6,
  parameter int TMR_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [N-1:0]     done_vec,
  input  logic [CNT_W-1:0] thr,
  input  logic [TMR_W-1:0] tmo,
  output logic             cc_q
);
  logic [CNT_W-1:0] pend;
  logic [TMR_W-1:0] age_q;
  logic             busy;

  assign pend = CNT_W'($countones(done_vec));
  assign busy = |done_vec;

  always_ff @(posedge clk) begin
    if (rst) begin
      age_q <= '0;
      cc_q  <= 1'b0;
    end else begin
      if (!busy)
        age_q <= '0;
      else if (age_q != '1)
        age_q <= age_q + 1'b1;
      cc_q <= busy && ((pend >= thr) || (age_q >= tmo));
    end
  end

  // an empty completed word never leaves command complete raised
  p_empty_no_cc_r8: assert property (@(posedge clk) disable iff (rst)
    !busy |=> !cc_q);

  // age timer is zero after any empty cycle
  p_age_restart_r7: assert property (@(posedge clk) disable iff (rst)
    !busy |=> (age_q == '0));
endmodule

// File: rtl/event_stat.sv
module event_stat #(
  parameter int NUM_EV = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [NUM_EV-1:0] ev_in,
  input  logic [NUM_EV-1:0] clr,
  output logic [NUM_EV-1:0] stat_q
);
  for (genvar i = 0; i < NUM_EV; i++) begin : g_bit
    always_ff @(posedge clk) begin
      if (rst)
        stat_q[i] <= 1'b0;
      else if (ev_in[i])
        stat_q[i] <= 1'b1;
      else if (clr[i])
        stat_q[i] <= 1'b0;
    end

    p_set_wins_r3: assert property (@(posedge clk) disable iff (rst)
      ev_in[i] |=> stat_q[i]);

    p_hold_r2: assert property (@(posedge clk) disable iff (rst)
      (stat_q[i] && !clr[i]) |=> stat_q[i]);
  end
endmodule

// File: rtl/link_state.sv
module link_state (
  input  logic clk,
  input  logic rst,
  input  logic ctl_we,
  input  logic ctl_on,
  input  logic active_any,
  output logic online_q,
  output logic going_q,
  output logic phy_rst_q,
  output logic accept
);
  logic online_d, going_d;

  always_comb begin
    online_d = online_q;
    going_d  = going_q;
    if (going_q) begin
      if (!active_any) begin
        online_d = 1'b0;
        going_d  = 1'b0;
      end
    end else if (ctl_we) begin
      if (ctl_on && !online_q)
        online_d = 1'b1;
      else if (!ctl_on && online_q)
        going_d = 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      online_q  <= 1'b0;
      going_q   <= 1'b0;
      phy_rst_q <= 1'b1;
    end else begin
      online_q  <= online_d;
      going_q   <= going_d;
      phy_rst_q <= !online_d;
    end
  end

  assign accept = online_q && !going_q;

  p_going_online_r9: assert property (@(posedge clk) disable iff (rst)
    going_q |-> online_q);

  p_drain_r9: assert property (@(posedge clk) disable iff (rst)
    $fell(online_q) |-> $past(going_q && !active_any));

  p_phy_r9: assert property (@(posedge clk) disable iff (rst)
    phy_rst_q |-> !going_q);
endmodule

// File: rtl/irq_coalesce_ctrl.sv
module irq_coalesce_ctrl
  import irqc_pkg::*;
#(
  parameter int N      = 32,
  parameter int NUM_EV = 8,
  parameter int DW     = 32,
  parameter int TMR_W  = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DW-1:0]     wr_data,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [DW-1:0]     rd_data,
  input  logic [NUM_EV-1:0] ev_in,
  input  logic [N-1:0]      cmd_issue,
  input  logic [N-1:0]      cmd_done,
  output logic              irq_o,
  output logic              phy_rst_o
);
  localparam int CNT_W = $clog2(N + 1);
  localparam int SRC_W = NUM_EV + 1;

  logic [NUM_EV-1:0] ev_q, ev_clr;
  logic [N-1:0]      done_q, done_clr;
  logic [SRC_W-1:0]  en_q, src;
  logic [CNT_W-1:0]  thr_q;
  logic [TMR_W-1:0]  tmo_q;
  logic              cc_q, active_any, online_q, going_q, accept, ctl_we;
  logic              irq_q;
  logic [DW-1:0]     rd_q, rd_d;

  assign ev_clr   = (wr_en && wr_addr == A_STAT) ? wr_data[NUM_EV:1] : '0;
  assign done_clr = (wr_en && wr_addr == A_DONE) ? wr_data[N-1:0] : '0;
  assign ctl_we   = wr_en && wr_addr == A_CTRL;
  assign src      = {ev_q, cc_q};

  event_stat #(.NUM_EV(NUM_EV)) i_ev (
    .clk(clk), .rst(rst), .ev_in(ev_in), .clr(ev_clr), .stat_q(ev_q));

  cmd_track #(.N(N)) i_trk (
    .clk(clk), .rst(rst), .accept(accept), .cmd_issue(cmd_issue),
    .cmd_done(cmd_done), .clr_mask(done_clr), .done_q(done_q),
    .active_any(active_any));

  coalesce_eng #(.N(N), .CNT_W(CNT_W), .TMR_W(TMR_W)) i_coal (
    .clk(clk), .rst(rst), .done_vec(done_q), .thr(thr_q), .tmo(tmo_q),
    .cc_q(cc_q));

  link_state i_link (
    .clk(clk), .rst(rst), .ctl_we(ctl_we), .ctl_on(wr_data[0]),
    .active_any(active_any), .online_q(online_q), .going_q(going_q),
    .phy_rst_q(phy_rst_o), .accept(accept));

  always_ff @(posedge clk) begin
    if (rst) begin
      en_q  <= '0;
      thr_q <= CNT_W'(1);
      tmo_q <= '1;
    end else if (wr_en) begin
      if (wr_addr == A_ENAB)
        en_q <= wr_data[SRC_W-1:0];
      if (wr_addr == A_COAL) begin
        thr_q <= wr_data[CNT_W-1:0];
        tmo_q <= wr_data[TMO_LSB +: TMR_W];
      end
    end
  end

  always_comb begin
    rd_d = '0;
    case (rd_addr)
      A_STAT: begin
        rd_d[SRC_W-1:0] = src;
        rd_d[DW-1]      = online_q;
        rd_d[DW-2]      = going_q;
      end
      A_ENAB: rd_d[SRC_W-1:0] = en_q;
      A_DONE: rd_d[N-1:0] = done_q;
      A_COAL: begin
        rd_d[CNT_W-1:0]         = thr_q;
        rd_d[TMO_LSB +: TMR_W]  = tmo_q;
      end
      A_CTRL: rd_d[0] = online_q;
      default: rd_d = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      irq_q <= 1'b0;
      rd_q  <= '0;
    end else begin
      irq_q <= |(src & en_q);
      rd_q  <= rd_d;
    end
  end

  assign irq_o   = irq_q;
  assign rd_data = rd_q;

  p_irq_quiet_r4: assert property (@(posedge clk) disable iff (rst)
    ((src & en_q) == '0) |=> !irq_o);

  p_irq_hold_r4: assert property (@(posedge clk) disable iff (rst)
    ((src & en_q) != '0) |=> irq_o);
endmodule

// File: tb/test_irq_coalesce_ctrl.sv
module test_irq_coalesce_ctrl;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wr_en = 1'b0;
  logic [2:0]  wr_addr = '0;
  logic [31:0] wr_data = '0;
  logic [2:0]  rd_addr = '0;
  logic [31:0] rd_data;
  logic [7:0]  ev_in = '0;
  logic [31:0] cmd_issue = '0;
  logic [31:0] cmd_done = '0;
  logic        irq_o, phy_rst_o;

  int n_chk = 0;
  int n_bad = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  irq_coalesce_ctrl i_irq_coalesce_ctrl (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .rd_data(rd_data), .ev_in(ev_in),
    .cmd_issue(cmd_issue), .cmd_done(cmd_done), .irq_o(irq_o),
    .phy_rst_o(phy_rst_o));

  task automatic step(int n = 1);
    for (int i = 0; i < n; i++) begin
      @(posedge clk);
      #1;
    end
  endtask

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(logic [2:0] a, logic [31:0] d);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    step();
    wr_en = 1'b0; wr_data = '0;
  endtask

  task automatic rd(logic [2:0] a, output logic [31:0] d);
    rd_addr = a;
    step();
    d = rd_data;
  endtask

  task automatic t_reset();
    logic [31:0] d;
    check("R1 irq", {31'b0, irq_o}, 32'd0);
    check("R1 phy_rst", {31'b0, phy_rst_o}, 32'd1);
    rd(3'd0, d); check("R1 status", d, 32'd0);
    rd(3'd1, d); check("R1 enable", d, 32'd0);
    rd(3'd2, d); check("R1 done", d, 32'd0);
    rd(3'd4, d); check("R1 ctrl", d, 32'd0);
  endtask

  task automatic t_events();
    logic [31:0] d;
    ev_in = 8'h04; step(); ev_in = '0;       // bit 3 set, enable off
    step();
    check("R2 irq masked", {31'b0, irq_o}, 32'd0);
    rd(3'd0, d); check("R2 status set", d, 32'h8);
    wr(3'd1, 32'h8);                          // enable bit 3
    check("R4 irq before", {31'b0, irq_o}, 32'd0);
    step();
    check("R4 irq rises", {31'b0, irq_o}, 32'd1);
    wr(3'd0, 32'h0);
    rd(3'd0, d); check("R3 write0 no effect", d, 32'h8);
    ev_in = 8'h04; wr_en = 1'b1; wr_addr = 3'd0; wr_data = 32'h8;
    step(); ev_in = '0; wr_en = 1'b0; wr_data = '0;
    rd(3'd0, d); check("R3 set wins", d, 32'h8);
    ev_in = 8'h01; step(); ev_in = '0;        // bit 1 set too
    wr(3'd1, 32'hA);
    wr(3'd0, 32'h8);                          // clear bit 3
    step();
    check("R4 irq held by other", {31'b0, irq_o}, 32'd1);
    wr(3'd0, 32'h2);                          // clear bit 1
    check("R4 irq before fall", {31'b0, irq_o}, 32'd1);
    step();
    check("R4 irq falls", {31'b0, irq_o}, 32'd0);
    rd(3'd0, d); check("R3 cleared", d, 32'h0);
  endtask

  task automatic t_count();
    logic [31:0] d;
    wr(3'd3, {16'd1000, 16'd3});
    rd(3'd3, d); check("R11 coal readback", d, {16'd1000, 16'd3});
    wr(3'd1, 32'h1);
    cmd_done = 32'h0000_0106; step(); cmd_done = '0;   // E1
    check("R6 irq at E1", {31'b0, irq_o}, 32'd0);
    step();                                            // E2 cc set
    check("R6 irq at E2", {31'b0, irq_o}, 32'd0);
    step();                                            // E3
    check("R6 irq at E3", {31'b0, irq_o}, 32'd1);
    rd(3'd2, d); check("R5 done readback", d, 32'h0000_0106);
    wr(3'd0, 32'h1);
    step();
    check("R8 status0 write ignored", {31'b0, irq_o}, 32'd1);
    cmd_done = 32'h0000_0100; wr_en = 1'b1; wr_addr = 3'd2; wr_data = 32'h0000_0100;
    step(); cmd_done = '0; wr_en = 1'b0; wr_data = '0;
    rd(3'd2, d); check("R5 set wins", d, 32'h0000_0106);
    wr(3'd2, 32'h0000_0002);                           // E4 count=2
    step();                                            // E5 cc clear
    check("R8 irq at E5", {31'b0, irq_o}, 32'd1);
    step();                                            // E6
    check("R8 irq falls", {31'b0, irq_o}, 32'd0);
    rd(3'd2, d); check("R5 cleared one", d, 32'h0000_0104);
    wr(3'd2, 32'hFFFF_FFFF);
    step(2);
  endtask

  task automatic age_run(string tag);
    cmd_done = 32'h0000_0010; step(); cmd_done = '0;   // E1 age 0
    step(6);                                           // E7 cc set
    check({tag, " irq at E7"}, {31'b0, irq_o}, 32'd0);
    step();                                            // E8
    check({tag, " irq at E8"}, {31'b0, irq_o}, 32'd1);
    wr(3'd2, 32'h0000_0010);
    step(2);
    check({tag, " irq after empty"}, {31'b0, irq_o}, 32'd0);
  endtask

  task automatic t_age();
    wr(3'd3, {16'd5, 16'd40});
    age_run("R7 first");
    step(3);
    age_run("R7 restart");
  endtask

  task automatic t_online();
    logic [31:0] d;
    wr(3'd1, 32'h0);
    cmd_issue = 32'h1; step(); cmd_issue = '0;         // ignored, offline
    wr(3'd4, 32'h1);
    check("R9 phy released", {31'b0, phy_rst_o}, 32'd0);
    wr(3'd4, 32'h0);                                   // going offline
    check("R10 no stale tag, still up", {31'b0, phy_rst_o}, 32'd0);
    step();
    check("R10 offline with none outstanding", {31'b0, phy_rst_o}, 32'd1);
    wr(3'd4, 32'h1);
    cmd_issue = 32'h6; step(); cmd_issue = '0;
    wr(3'd4, 32'h0);
    cmd_issue = 32'h8; step(); cmd_issue = '0;         // ignored, draining
    rd(3'd0, d); check("R9 going offline bits", d & 32'hC000_0000, 32'hC000_0000);
    cmd_done = 32'h2; step(); cmd_done = '0;
    step();
    check("R9 still draining", {31'b0, phy_rst_o}, 32'd0);
    cmd_done = 32'h4; step(); cmd_done = '0;           // active empty here
    check("R10 draining tag ignored", {31'b0, phy_rst_o}, 32'd0);
    step();
    check("R9 offline after drain", {31'b0, phy_rst_o}, 32'd1);
    rd(3'd0, d); check("R9 status bits clear", d & 32'hC000_0000, 32'h0);
    wr(3'd2, 32'hFFFF_FFFF);
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    step(3);
    rst = 1'b0;
    step();
    t_reset();
    t_events();
    t_count();
    t_age();
    t_online();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule